// File: doc/BRIEF.md
# Output Window Compare Checker

This block judges one output pin of a circuit under test, one tester slice at a time. A slice begins with a start strobe (t0). Two marker strobes, t1 and t2, bound a compare window. For every clock tick inside the window, the sampled pin value and its high-impedance flag are compared against an expected sense code. Ticks outside the window are masked and never count against the pin.

Each window runs in one of two modes. A normal window opens at t1 and closes at t2 of the same slice. A skew window opens at t1 and stays open across the next slice start, closing at t2 of the following slice. Two windows can therefore be open at once, so the block keeps two independent window trackers.

When a window closes, a one-cycle result pulse reports pass or fail. Every failed window adds to a saturating error count that only reset clears.

Top module: `wcmp_window_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid`, `res_fail` and `err_count` are all zero.
- R2: A normal window compares the pin on every tick from the tick where `t1_mark` is high through the tick where `t2_mark` is high, both included. Pin values outside that span have no effect on the result.
- R3: A skew window compares from its `t1_mark` tick through the `t2_mark` tick of the following slice, both included. The `t2_mark` of the slice where it opened is ignored, and the pin between that `t2_mark` and the next `slice_start` is compared.
- R4: `exp_code` encodings: 0 = don't-care, 1 = expect low, 2 = expect high, 3 = expect high-impedance, 4 = expect unknown. Codes 0, 4, 5, 6 and 7 never fail, whatever the pin does.
- R5: With code 1 or 2, the window fails if, on any compared tick, `pin_hiz` is high or `pin_val` differs from the expected level.
- R6: With code 3, the window passes only if `pin_hiz` is high on every compared tick.
- R7: If `t2_mark` closes a window at clock edge k, `res_valid` is high for exactly the one cycle following edge k+1. `res_fail` is high in that cycle only if the result is a failure, and is low whenever `res_valid` is low.
- R8: `exp_code` and `skew_mode` are captured on the window's `t1_mark` tick and held until that window closes. Later changes to those inputs, including a following slice's code, do not affect the open window.
- R9: Up to two windows may be open at once, and a new window takes the lowest-numbered free tracker. When two windows close on the same tick, a single result is posted, failing if either window failed.
- R10: `err_count` (CNT_W bits, default 16) rises by the number of failed windows in each posted result, in the same cycle as `res_valid`. It saturates at its all-ones value and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slice_start | input | 1 | Start-of-slice (t0) strobe |
| t1_mark | input | 1 | Window-open marker strobe |
| t2_mark | input | 1 | Window-close marker strobe |
| exp_code | input | 3 | Expected sense code, taken at t1 |
| skew_mode | input | 1 | 1 = skew window, 0 = normal window, taken at t1 |
| pin_val | input | 1 | Sampled logic level of the pin |
| pin_hiz | input | 1 | Pin is high-impedance on this tick |
| res_valid | output | 1 | One-cycle pulse carrying a window result |
| res_fail | output | 1 | Window failed (qualified by res_valid) |
| err_count | output | CNT_W (16) | Saturating count of failed windows |

## Verification
A `t2_mark` sampled at edge k shows up two edges later: the tracker records the close at edge k, and the result stage drives `res_valid`, `res_fail` and the updated `err_count` at edge k+1. The reference model in the bench is clocked on the same edges as the design. It produces the outputs the design should show after each edge, and the bench compares them at the following falling edge, so any result that arrives a cycle early or late is caught. Glitches are placed exactly on the t1 tick, on the t2 tick, and one tick outside each edge of the window. Skew windows are run back to back, so closes in one cycle overlap and the result merge is exercised.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

    typedef enum logic [2:0] {
        EXP_DC  = 3'd0,
        EXP_LO  = 3'd1,
        EXP_HI  = 3'd2,
        EXP_HIZ = 3'd3,
        EXP_ANY = 3'd4
    } exp_code_e;

    typedef enum logic [1:0] {
        LN_IDLE    = 2'd0,
        LN_WAIT_T0 = 2'd1,
        LN_OPEN    = 2'd2
    } lane_st_e;

    typedef struct packed {
        logic done;
        logic fail;
    } lane_res_t;

    // 1 when this tick violates the expectation
    function automatic logic tick_miss(input logic [2:0] code, input logic val, input logic hiz);
        case (code)
            EXP_LO:  return hiz | val;
            EXP_HI:  return hiz | ~val;
            EXP_HIZ: return ~hiz;
            default: return 1'b0;
        endcase
    endfunction

    // 1 for codes that can never fail
    function automatic logic code_is_free(input logic [2:0] code);
        return !(code == EXP_LO || code == EXP_HI || code == EXP_HIZ);
    endfunction

endpackage

// File: rtl/wcmp_lane.sv
module wcmp_lane
    import wcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      grant,
    input  logic      slice_start,
    input  logic      t2_mark,
    input  logic [2:0] exp_code,
    input  logic      skew_mode,
    input  logic      pin_val,
    input  logic      pin_hiz,
    output logic      idle,
    output lane_res_t res
);

    lane_st_e   st;
    logic [2:0] code_q;
    logic       bad_q;
    logic       miss_new;
    logic       miss_held;

    assign miss_new  = tick_miss(exp_code, pin_val, pin_hiz);
    assign miss_held = tick_miss(code_q, pin_val, pin_hiz);
    assign idle      = (st == LN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LN_IDLE;
            code_q <= EXP_DC;
            bad_q  <= 1'b0;
            res    <= '0;
        end else begin
            res <= '0;
            case (st)
                LN_IDLE: begin
                    if (grant) begin
                        code_q <= exp_code;
                        bad_q  <= miss_new;
                        st     <= skew_mode ? LN_WAIT_T0 : LN_OPEN;
                    end
                end
                LN_WAIT_T0: begin
                    bad_q <= bad_q | miss_held;
                    if (slice_start) st <= LN_OPEN;
                end
                LN_OPEN: begin
                    bad_q <= bad_q | miss_held;
                    if (t2_mark) begin
                        res.done <= 1'b1;
                        res.fail <= bad_q | miss_held;
                        st       <= LN_IDLE;
                    end
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    // R4: a window with a non-failing code never reports failure
    p_free_code_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (res.done && code_is_free(code_q)) |-> !res.fail);

    // R7: a lane close is a single-cycle event
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        res.done |=> !res.done);

    // R9: the allocator only hands windows to free lanes
    p_grant_idle_r9: assert property (@(posedge clk) disable iff (rst)
        grant |-> idle);

endmodule

// File: rtl/wcmp_post.sv
module wcmp_post #(
    parameter int LANES = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] done_v,
    input  logic [LANES-1:0] fail_v,
    output logic             res_valid,
    output logic             res_fail,
    output logic [CNT_W-1:0] err_count
);

    localparam int NF_W  = $clog2(LANES + 1);
    localparam int SUM_W = CNT_W + NF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NF_W-1:0]  nfail;
    logic [SUM_W-1:0] sum;

    always_comb begin
        nfail = '0;
        for (int i = 0; i < LANES; i++) begin
            if (done_v[i] && fail_v[i]) nfail = nfail + NF_W'(1);
        end
        sum = SUM_W'(err_count) + SUM_W'(nfail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fail  <= 1'b0;
            err_count <= '0;
        end else begin
            res_valid <= |done_v;
            res_fail  <= |(done_v & fail_v);
            if (sum > SUM_W'(CNT_MAX)) err_count <= CNT_MAX;
            else                       err_count <= sum[CNT_W-1:0];
        end
    end

    // R7: failure flag only accompanies a valid result
    p_fail_valid_r7: assert property (@(posedge clk) disable iff (rst)
        res_fail |-> res_valid);

    // R10: count moves only with a posted failure
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_fail) |-> $stable(err_count));

    // R10: saturated count stays saturated
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (err_count == CNT_MAX) |=> (err_count == CNT_MAX));

endmodule

// File: rtl/wcmp_window_checker.sv
module wcmp_window_checker
    import wcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slice_start,
    input  logic             t1_mark,
    input  logic             t2_mark,
    input  logic [2:0]       exp_code,
    input  logic             skew_mode,
    input  logic             pin_val,
    input  logic             pin_hiz,
    output logic             res_valid,
    output logic             res_fail,
    output logic [CNT_W-1:0] err_count
);

    localparam int LANES = 2;

    logic [LANES-1:0] idle_v;
    logic [LANES-1:0] grant_v;
    logic [LANES-1:0] done_v;
    logic [LANES-1:0] fail_v;

    // lowest free lane takes the new window
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_v = '0;
        for (int i = 0; i < LANES; i++) begin
            if (t1_mark && idle_v[i] && !taken) begin
                grant_v[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lane_res_t lres;
            wcmp_lane u_lane (
                .clk         (clk),
                .rst         (rst),
                .grant       (grant_v[g]),
                .slice_start (slice_start),
                .t2_mark     (t2_mark),
                .exp_code    (exp_code),
                .skew_mode   (skew_mode),
                .pin_val     (pin_val),
                .pin_hiz     (pin_hiz),
                .idle        (idle_v[g]),
                .res         (lres)
            );
            assign done_v[g] = lres.done;
            assign fail_v[g] = lres.fail;
        end
    endgenerate

    wcmp_post #(.LANES(LANES), .CNT_W(CNT_W)) u_post (
        .clk       (clk),
        .rst       (rst),
        .done_v    (done_v),
        .fail_v    (fail_v),
        .res_valid (res_valid),
        .res_fail  (res_fail),
        .err_count (err_count)
    );

    // R7: a result appears two edges after a closing t2 marker
    p_valid_after_t2_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(t2_mark, 2));

endmodule

// File: tb/wcmp_window_checker_tb_top.sv
`timescale 1ns/1ps
module wcmp_window_checker_tb_top;

    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slice_start = 0, t1_mark = 0, t2_mark = 0, skew_mode = 0;
    logic pin_val = 0, pin_hiz = 0;
    logic [2:0] exp_code = 0;
    logic res_valid, res_fail;
    logic [CW-1:0] err_count;

    int checks = 0, failures = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    wcmp_window_checker #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .slice_start(slice_start), .t1_mark(t1_mark),
        .t2_mark(t2_mark), .exp_code(exp_code), .skew_mode(skew_mode),
        .pin_val(pin_val), .pin_hiz(pin_hiz), .res_valid(res_valid),
        .res_fail(res_fail), .err_count(err_count)
    );

    // ---------------- reference model ----------------
    int  w_st[2];     // 0 free, 1 waiting for next t0, 2 open
    int  w_code[2];
    bit  w_bad[2];
    bit  pend_v, pend_f;
    int  pend_n;
    bit  e_v, e_f;
    int  e_cnt;

    function automatic bit miss(int c, bit v, bit h);
        if (c == 1) return h || v;
        if (c == 2) return h || !v;
        if (c == 3) return !h;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (w_st[i]) begin w_st[i] = 0; w_bad[i] = 0; w_code[i] = 0; end
            pend_v = 0; pend_f = 0; pend_n = 0;
            e_v = 0; e_f = 0; e_cnt = 0;
        end else begin
            int was[2];
            bit placed;
            e_v = pend_v; e_f = pend_f;
            if (pend_v) e_cnt = (e_cnt + pend_n > CMAX) ? CMAX : e_cnt + pend_n;
            pend_v = 0; pend_f = 0; pend_n = 0;
            foreach (w_st[i]) was[i] = w_st[i];
            foreach (w_st[i]) begin
                if (was[i] != 0) begin
                    w_bad[i] = w_bad[i] || miss(w_code[i], pin_val, pin_hiz);
                    if (was[i] == 1 && slice_start) w_st[i] = 2;
                    else if (was[i] == 2 && t2_mark) begin
                        pend_v = 1;
                        if (w_bad[i]) begin pend_f = 1; pend_n++; end
                        w_st[i] = 0;
                    end
                end
            end
            placed = 0;
            if (t1_mark) foreach (w_st[i]) begin
                if (!placed && was[i] == 0) begin
                    placed = 1;
                    w_code[i] = exp_code;
                    w_bad[i] = miss(exp_code, pin_val, pin_hiz);
                    w_st[i] = skew_mode ? 1 : 2;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst || cur_req == "R1") begin
            checks++;
            if (res_valid !== 0 || res_fail !== 0 || err_count !== 0) begin
                failures++;
                $display("FAIL R1 reset state: valid=%b fail=%b cnt=%0d expected 0 0 0",
                         res_valid, res_fail, err_count);
            end
        end else begin
            checks++;
            if (res_valid !== e_v || res_fail !== e_f || err_count !== CW'(e_cnt)) begin
                failures++;
                $display("FAIL %s at %0t: valid=%b fail=%b cnt=%0d expected valid=%b fail=%b cnt=%0d",
                         cur_req, $time, res_valid, res_fail, err_count, e_v, e_f, e_cnt);
            end
        end
    end

    // ---------------- stimulus ----------------
    // one slice of len ticks; t1p/t2p = -1 for no marker; glitch tick g replaces the pin
    task automatic run_slice(int len, int t1p, int t2p, int code, int code_late, bit skew,
                             bit pv, bit ph, int g, bit gv, bit gh);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            slice_start = (k == 0);
            t1_mark     = (k == t1p);
            t2_mark     = (k == t2p);
            exp_code    = (t1p >= 0 && k > t1p) ? 3'(code_late) : 3'(code);
            skew_mode   = (t1p >= 0 && k > t1p) ? !skew : skew;
            pin_val     = (k == g) ? gv : pv;
            pin_hiz     = (k == g) ? gh : ph;
        end
    endtask

    task automatic quiet(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            slice_start = 0; t1_mark = 0; t2_mark = 0;
            pin_val = 0; pin_hiz = 0; exp_code = 0; skew_mode = 0;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);              // R1: first cycle after reset also zero
        cur_req = "R2";
        // R2: steady high, glitches just outside the window
        run_slice(10, 3, 6, 2, 2, 0, 1, 0, -1, 0, 0);
        run_slice(10, 3, 6, 2, 2, 0, 1, 0, 2, 0, 0);
        run_slice(10, 3, 6, 2, 2, 0, 1, 0, 7, 0, 1);
        quiet(3);
        cur_req = "R5";
        // R5: glitch on the t1 tick, on the t2 tick, and mid-window high-Z
        run_slice(10, 3, 6, 1, 1, 0, 0, 0, 3, 1, 0);
        run_slice(10, 3, 6, 1, 1, 0, 0, 0, 6, 1, 0);
        run_slice(10, 3, 6, 2, 2, 0, 1, 0, 4, 1, 1);
        run_slice(10, 2, 5, 1, 1, 0, 0, 0, -1, 0, 0);
        quiet(3);
        cur_req = "R6";
        run_slice(10, 3, 6, 3, 3, 0, 0, 1, -1, 0, 0);
        run_slice(10, 3, 6, 3, 3, 0, 0, 1, 5, 0, 0);
        quiet(3);
        cur_req = "R4";
        run_slice(10, 3, 6, 0, 0, 0, 1, 1, 4, 0, 0);
        run_slice(10, 3, 6, 4, 4, 0, 0, 1, 4, 1, 0);
        run_slice(10, 3, 6, 6, 6, 0, 1, 0, 5, 0, 1);
        quiet(3);
        cur_req = "R8";
        // code and mode flip after t1; window keeps its captured values
        run_slice(10, 3, 6, 2, 1, 0, 1, 0, -1, 0, 0);
        run_slice(10, 3, 6, 3, 2, 0, 0, 1, -1, 0, 0);
        quiet(3);
        cur_req = "R3";
        // skew: pin between own-slice t2 and next t0 is compared
        run_slice(10, 3, 6, 2, 0, 1, 1, 0, -1, 0, 0);
        run_slice(10, -1, 4, 0, 0, 0, 1, 0, -1, 0, 0);
        run_slice(10, 3, 6, 2, 0, 1, 1, 0, 8, 0, 0);
        run_slice(10, -1, 4, 0, 0, 0, 1, 0, -1, 0, 0);
        run_slice(10, 3, 6, 1, 0, 1, 0, 0, -1, 0, 0);
        run_slice(10, -1, 4, 0, 0, 0, 0, 0, 4, 1, 0);
        run_slice(10, 3, 6, 1, 0, 1, 0, 0, -1, 0, 0);
        run_slice(10, -1, 4, 0, 0, 0, 0, 0, 5, 1, 0);
        quiet(3);
        cur_req = "R9";
        // back-to-back skew windows overlap; last closes with a normal window
        run_slice(8, 2, 5, 2, 2, 1, 1, 0, -1, 0, 0);
        run_slice(8, 2, 5, 1, 1, 1, 1, 0, 1, 1, 0);
        run_slice(8, 2, 5, 3, 3, 1, 0, 0, -1, 0, 0);
        run_slice(8, 2, 5, 0, 0, 0, 1, 1, -1, 0, 0);
        run_slice(8, 2, 5, 2, 2, 1, 1, 0, -1, 0, 0);
        run_slice(8, 2, 5, 1, 1, 0, 1, 0, -1, 0, 0);
        quiet(3);
        cur_req = "R10";
        for (int n = 0; n < 16; n++) run_slice(6, 1, 3, 1, 1, 0, 1, 0, -1, 0, 0);
        run_slice(8, 2, 5, 1, 1, 1, 1, 0, -1, 0, 0);
        run_slice(8, 2, 5, 2, 2, 0, 0, 0, -1, 0, 0);
        quiet(4);
        cur_req = "R7";
        run_slice(7, 1, 2, 2, 2, 0, 0, 0, -1, 0, 0);
        quiet(4);
        checks++;
        if (err_count !== CW'(CMAX)) begin
            failures++;
            $display("FAIL R10 saturation: cnt=%0d expected %0d", err_count, CMAX);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule